// File: doc/BRIEF.md
# Clock Gate Set/Clear Register Bank

This block holds the gating state for three banks of peripheral clocks and drives one enable level per clock. Software changes a bank without reading it first. Each bank has its own set address and its own clear address. A 1 in the written mask at the set address stops that clock. A 1 in the written mask at the clear address lets that clock run again. A 0 in the mask leaves that position as it was, so a single-bit mask changes exactly one clock.

Only some bit positions in each bank carry a real gate. Every other position stays 0, ignores writes and has its enable output held low. The enables are registered levels meant for glitch-free gating cells outside this block. Reading either address of a bank returns that bank's current gating state.

Top module: `clock_gate_bank`

## Requirements
- R1: After reset every gating bit is 0. Every populated enable is 1, every unpopulated enable is 0, and reads of any bank return 0.
- R2: A write to a bank's set address ORs the mask into that bank's populated gating bits. The set addresses are 0x50 for bank 0, 0x54 for bank 1 and 0xA0 for bank 2.
- R3: A write to a bank's clear address clears every gating bit that is 1 in the mask. The clear addresses are 0x80 for bank 0, 0x84 for bank 1 and 0xB0 for bank 2.
- R4: Mask positions holding 0 leave the corresponding gating bits unchanged. An all-zero mask changes nothing.
- R5: A read at either the set or the clear address of a bank returns that bank's gating state on `rd_data`, combinationally. In a cycle that also writes, the read shows the state from before that write.
- R6: Only these positions are populated: bank 0 bit 2; bank 1 bits 1, 3, 4, 16, 20, 29 and 30; bank 2 bits 6 to 11. All other positions read 0, ignore writes and have enable 0.
- R7: `clk_en` bit 32*b+i is the inverse of gating bit i of bank b, for populated positions. It is registered and changes at the same clock edge that updates the gating state.
- R8: A write to any other address, including unaligned ones such as 0x51, has no effect. A read of such an address returns 0.
- R9: A write to one bank never changes another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write mask |
| rd_data | output | 32 | Combinational read data for `bus_addr` |
| clk_en | output | 96 | Registered clock enables, 32 per bank |

## Verification
A read and a write can address the same bank in the same cycle, because the read port is combinational and always decodes `bus_addr`. The bench drives a set write with the address pointing at the bank being changed. During that cycle it samples `rd_data` and the affected enable, and both must still show the old state. On the next cycle it checks that both have moved to the new state together.

// File: rtl/cgb_pkg.sv
package cgb_pkg;

    localparam int CGB_BANKS = 3;
    localparam int CGB_DW    = 32;
    localparam int CGB_AW    = 8;

    typedef enum logic [1:0] {
        CGB_OP_NONE,
        CGB_OP_SET,
        CGB_OP_CLR
    } cgb_op_e;

    // Address of the write-one-to-stop port of each bank
    function automatic logic [31:0] cgb_set_off(input int b);
        case (b)
            0:       return 32'h50;
            1:       return 32'h54;
            2:       return 32'hA0;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Address of the write-one-to-run port of each bank
    function automatic logic [31:0] cgb_clr_off(input int b);
        case (b)
            0:       return 32'h80;
            1:       return 32'h84;
            2:       return 32'hB0;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Positions that carry a real gate in each bank
    function automatic logic [31:0] cgb_pop_mask(input int b);
        case (b)
            0:       return 32'h0000_0004;
            1:       return 32'h6011_001A;
            2:       return 32'h0000_0FC0;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/cgb_addr_decode.sv
module cgb_addr_decode
    import cgb_pkg::*;
#(
    parameter int ADDR_W    = CGB_AW,
    parameter int NUM_BANKS = CGB_BANKS,
    parameter int BIDX_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output cgb_op_e           op,
    output logic [BIDX_W-1:0] bank,
    output logic              hit
);

    always_comb begin
        op   = CGB_OP_NONE;
        bank = '0;
        hit  = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(cgb_set_off(b))) begin
                hit  = 1'b1;
                bank = BIDX_W'(b);
                if (wr) op = CGB_OP_SET;
            end else if (addr == ADDR_W'(cgb_clr_off(b))) begin
                hit  = 1'b1;
                bank = BIDX_W'(b);
                if (wr) op = CGB_OP_CLR;
            end
        end
    end

endmodule

// File: rtl/cgb_gate_bank.sv
module cgb_gate_bank
    import cgb_pkg::*;
#(
    parameter int              DATA_W = CGB_DW,
    parameter logic [DATA_W-1:0] POP  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  cgb_op_e           op,
    input  logic [DATA_W-1:0] wmask,
    output logic [DATA_W-1:0] gate_q,
    output logic [DATA_W-1:0] en_q
);

    logic [DATA_W-1:0] gate_d;

    always_comb begin
        gate_d = gate_q;
        if (sel) begin
            unique case (op)
                CGB_OP_SET:  gate_d = gate_q | (wmask & POP);
                CGB_OP_CLR:  gate_d = gate_q & ~wmask;
                CGB_OP_NONE: gate_d = gate_q;
                default:     gate_d = gate_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
            en_q   <= POP;
        end else begin
            gate_q <= gate_d;
            en_q   <= ~gate_d & POP;
        end
    end

endmodule

// File: rtl/clock_gate_bank.sv
module clock_gate_bank
    import cgb_pkg::*;
#(
    parameter int ADDR_W    = CGB_AW,
    parameter int DATA_W    = CGB_DW,
    parameter int NUM_BANKS = CGB_BANKS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           rd_data,
    output logic [NUM_BANKS*DATA_W-1:0] clk_en
);

    localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    cgb_op_e                     dec_op;
    logic [BIDX_W-1:0]           dec_bank;
    logic                        dec_hit;
    logic [NUM_BANKS*DATA_W-1:0] gate_all;

    cgb_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_BANKS(NUM_BANKS),
        .BIDX_W   (BIDX_W)
    ) i_decode (
        .addr(bus_addr),
        .wr  (bus_wr),
        .op  (dec_op),
        .bank(dec_bank),
        .hit (dec_hit)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        cgb_gate_bank #(
            .DATA_W(DATA_W),
            .POP   (DATA_W'(cgb_pop_mask(b)))
        ) i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (dec_bank == BIDX_W'(b)),
            .op    (dec_op),
            .wmask (bus_wdata),
            .gate_q(gate_all[b*DATA_W +: DATA_W]),
            .en_q  (clk_en[b*DATA_W +: DATA_W])
        );
    end

    always_comb begin
        rd_data = '0;
        if (dec_hit) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (dec_bank == BIDX_W'(b)) rd_data = gate_all[b*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/cgb_checker.sv
module cgb_checker
    import cgb_pkg::*;
#(
    parameter int ADDR_W    = CGB_AW,
    parameter int DATA_W    = CGB_DW,
    parameter int NUM_BANKS = CGB_BANKS
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_wr,
    input logic [DATA_W-1:0]           bus_wdata,
    input logic [DATA_W-1:0]           rd_data,
    input logic [NUM_BANKS*DATA_W-1:0] clk_en,
    input logic [NUM_BANKS*DATA_W-1:0] gate_all
);

    logic mapped;
    always_comb begin
        mapped = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == ADDR_W'(cgb_set_off(b)) || bus_addr == ADDR_W'(cgb_clr_off(b)))
                mapped = 1'b1;
        end
    end

    // R8: unmapped reads return 0
    a_r8_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> rd_data == '0);

    // R8: unmapped writes leave every gate unchanged
    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped) |=> $stable(gate_all));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        localparam logic [DATA_W-1:0] PM = DATA_W'(cgb_pop_mask(b));

        // R2: populated mask bits are set after a set write
        a_r2_set_write: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(cgb_set_off(b))) |=>
            ((gate_all[b*DATA_W +: DATA_W] & $past(bus_wdata & PM)) == $past(bus_wdata & PM)));

        // R3: mask bits are clear after a clear write
        a_r3_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(cgb_clr_off(b))) |=>
            ((gate_all[b*DATA_W +: DATA_W] & $past(bus_wdata)) == '0));

        // R5: both addresses of a bank read its state
        a_r5_readback: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr == ADDR_W'(cgb_set_off(b)) || bus_addr == ADDR_W'(cgb_clr_off(b))) |->
            rd_data == gate_all[b*DATA_W +: DATA_W]);

        // R6: unpopulated positions stay 0
        a_r6_unpop_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_all[b*DATA_W +: DATA_W] & ~PM) == '0);

        // R7: enables are the inverse of the gates
        a_r7_en_tracks: assert property (@(posedge clk) disable iff (!rst_n)
            clk_en[b*DATA_W +: DATA_W] == (~gate_all[b*DATA_W +: DATA_W] & PM));
    end

endmodule

bind clock_gate_bank cgb_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_BANKS(NUM_BANKS)
) i_cgb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .rd_data  (rd_data),
    .clk_en   (clk_en),
    .gate_all (gate_all)
);

// File: tb/test_clock_gate_bank.sv
`timescale 1ns/1ps
module test_clock_gate_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic [95:0] clk_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    clock_gate_bank i_clock_gate_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .rd_data  (rd_data),
        .clk_en   (clk_en)
    );

    localparam logic [31:0] BPOP [3] = '{32'h0000_0004, 32'h6011_001A, 32'h0000_0FC0};
    localparam logic [7:0]  BSET [3] = '{8'h50, 8'h54, 8'hA0};
    localparam logic [7:0]  BCLR [3] = '{8'h80, 8'h84, 8'hB0};

    logic [31:0] model [3] = '{32'h0, 32'h0, 32'h0};

    typedef struct packed {
        logic [15:0] tag;
        logic        wr;
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{"R2", 1'b1, 8'h54, 32'hFFFF_FFFF, 8'h54, 32'h6011_001A},
        '{"R3", 1'b1, 8'h84, 32'h0000_0008, 8'h54, 32'h6011_0012},
        '{"R5", 1'b1, 8'hA0, 32'h0000_0140, 8'hB0, 32'h0000_0140},
        '{"R6", 1'b1, 8'h50, 32'h0000_0005, 8'h80, 32'h0000_0004},
        '{"R8", 1'b1, 8'h58, 32'hFFFF_FFFF, 8'h58, 32'h0000_0000},
        '{"R9", 1'b0, 8'h00, 32'h0000_0000, 8'h54, 32'h6011_0012},
        '{"R3", 1'b1, 8'hB0, 32'hFFFF_FFFF, 8'hA0, 32'h0000_0000},
        '{"R4", 1'b1, 8'h80, 32'h0000_0000, 8'h50, 32'h0000_0004},
        '{"R4", 1'b1, 8'h84, 32'h6000_0000, 8'h84, 32'h0011_0012},
        '{"R2", 1'b1, 8'hA0, 32'h0000_0800, 8'hA0, 32'h0000_0800},
        '{"R8", 1'b1, 8'h51, 32'hFFFF_FFFF, 8'h50, 32'h0000_0004}
    };

    task automatic check(input logic [95:0] act, input logic [95:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [95:0] model_en();
        logic [95:0] e;
        for (int b = 0; b < 3; b++) e[b*32 +: 32] = ~model[b] & BPOP[b];
        return e;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        for (int b = 0; b < 3; b++) begin
            if (a == BSET[b]) model[b] = model[b] | (d & BPOP[b]);
            if (a == BCLR[b]) model[b] = model[b] & ~d;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        bus_addr = 8'h54;
        #1;
        check({64'h0, rd_data}, 96'h0, "R1 read");
        check(clk_en, {BPOP[2], BPOP[1], BPOP[0]}, "R1 enables");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            bus_wr    = VECS[i].wr;
            bus_addr  = VECS[i].waddr;
            bus_wdata = VECS[i].wdata;
            if (VECS[i].wr) model_write(VECS[i].waddr, VECS[i].wdata);
            @(negedge clk);
            bus_wr   = 1'b0;
            bus_addr = VECS[i].raddr;
            #1;
            check({64'h0, rd_data}, {64'h0, VECS[i].exp}, $sformatf("%s read vec %0d", VECS[i].tag, i));
            check(clk_en, model_en(), $sformatf("R7 enables vec %0d", i));
        end

        // R5/R7: read and write to the same bank in one cycle
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = 8'hA0;
        bus_wdata = 32'h0000_0040;
        #1;
        check({64'h0, rd_data}, 96'h800, "R5 read during write");
        check({95'h0, clk_en[70]}, 96'h1, "R7 enable before edge");
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        check({64'h0, rd_data}, 96'h840, "R5 read after write");
        check({95'h0, clk_en[70]}, 96'h0, "R7 enable after edge");
        check({64'h0, clk_en[95:64]}, {64'h0, ~32'h840 & BPOP[2]}, "R9 bank2 only");

        // R6: unpopulated bank 2 bit 12 ignores a set write, enable stays 0
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = 8'hA0;
        bus_wdata = 32'h0000_1000;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
        check({64'h0, rd_data}, 96'h840, "R6 unpopulated write");
        check({95'h0, clk_en[76]}, 96'h0, "R6 unpopulated enable");

        // R1: reset mid-run clears all gates
        rst_n = 1'b0;
        #1;
        check(clk_en, {BPOP[2], BPOP[1], BPOP[0]}, "R1 reset enables");
        check({64'h0, rd_data}, 96'h0, "R1 reset read");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule